// File: doc/BRIEF.md
# Burst-Capable Strobe Bus Write Slave

This block sits between an asynchronous, strobe-driven processor bus and a clocked register file. The processor presents a 9-bit address and pulses the address strobe to load a starting address. It then runs write cycles. In each cycle it drives the write/read select low and the data byte onto the bus, then pulls the data strobe low. The block answers with an active-low data acknowledge once a settle interval has passed. It takes the byte as the data strobe returns high. Each finished write cycle produces a single-cycle write pulse toward the register file, carrying an address and a byte.

Bursts need no address traffic between cycles. After the address strobe has loaded an address, the first write cycle goes to that address. Each further write cycle increments the address by one, wrapping at the top of the 9-bit space. A fresh address strobe restarts the burst at the new address. All four bus controls pass through two-flop synchronisers into the core clock, and edges are detected there. A handshake state machine with the states IDLE, SETTLE, ACK and COMMIT paces each cycle. The transitions are:

- IDLE to SETTLE on a valid write strobe fall.
- SETTLE to ACK when the settle count expires.
- SETTLE or ACK to COMMIT on the strobe rise.
- COMMIT to IDLE unconditionally.

Top module: `burst_bus_slave`

## Requirements
- R1: After reset `dtack_n` is high (1) and `wr_en` is low (0), and no write pulse appears until a write cycle completes.
- R2: A falling edge of the synchronised `as_n` while the synchronised `cs_n` is low (0) loads `bus_addr`. The next write cycle commits to exactly that address (offset 0).
- R3: Each later write cycle without a new address strobe commits to the previous write address plus one.
- R4: Address increment wraps from 0x1FF to 0x000.
- R5: A write cycle starts when the synchronised `ds_n` falls while the synchronised `cs_n` is low (0) and `rw_n` is low (0, write). If `ds_n` is first sampled low at rising edge n, `dtack_n` goes low after edge n+2+SETTLE_CYC (default SETTLE_CYC = 2).
- R6: If `ds_n` is first sampled high at edge m during ACK, `dtack_n` returns high after edge m+2. `wr_en` is high for exactly that one cycle, and `wr_en` and an active `dtack_n` never coincide.
- R7: `wr_data` during the write pulse equals the byte held on `bus_data` while the strobe was low.
- R8: A data strobe with `cs_n` high (1) is ignored. It brings no acknowledge and no write pulse, and the address does not advance.
- R9: A data strobe with `rw_n` high (1, read) is ignored in the same way: no acknowledge, no write pulse, no address advance.
- R10: An address strobe in the middle of a burst restarts it. The next write commits to the newly loaded address, and later writes count up from there.
- R11: If the data strobe returns high before the acknowledge is given, the cycle still commits exactly once, and `dtack_n` stays high throughout.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low, asynchronous |
| as_n | input | 1 | Address strobe, active low, asynchronous |
| rw_n | input | 1 | Read/write select, low = write |
| ds_n | input | 1 | Data strobe, active low, asynchronous |
| bus_addr | input | 9 | Processor address |
| bus_data | input | 8 | Processor write data |
| dtack_n | output | 1 | Data acknowledge, active low |
| wr_en | output | 1 | Single-cycle register-file write strobe |
| wr_addr | output | 9 | Register-file write address |
| wr_data | output | 8 | Register-file write data |

## Verification
Each strobe edge shows up at the outputs after a fixed number of edges. Two synchroniser flops and one edge-detect flop put the FSM decision two edges after the first sample. The acknowledge then follows SETTLE_CYC edges later, and the release and write pulse follow two edges after the strobe is first sampled high. A behavioural model in the bench keeps a three-deep history of raw samples to reproduce these delays, and its outputs are compared with the design at every falling clock edge. Directed checks count falling edges from the stimulus to the expected output change, using SETTLE_CYC+3 for the acknowledge and 3 for the release. They also read every committed address and byte from a queue filled at falling edges.

// File: rtl/bbs_pkg.sv
package bbs_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SETTLE = 2'd1,
        ST_ACK    = 2'd2,
        ST_COMMIT = 2'd3
    } bbs_state_e;

    localparam int unsigned CTRL_W = 4;
    localparam int unsigned IDX_CS = 0;
    localparam int unsigned IDX_AS = 1;
    localparam int unsigned IDX_RW = 2;
    localparam int unsigned IDX_DS = 3;

endpackage

// File: rtl/bbs_sync.sv
module bbs_sync #(
    parameter int unsigned W      = 4,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_raw,
    output logic [W-1:0] q,
    output logic [W-1:0] q_prev
);

    // pipe[0..STAGES-1] synchronise, pipe[STAGES] holds the previous value
    logic [STAGES:0][W-1:0] pipe;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pipe[0] <= '1;
        end else begin
            pipe[0] <= d_raw;
        end
    end

    generate
        for (genvar i = 1; i <= STAGES; i++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    pipe[i] <= '1;
                end else begin
                    pipe[i] <= pipe[i-1];
                end
            end
        end
    endgenerate

    assign q      = pipe[STAGES-1];
    assign q_prev = pipe[STAGES];

endmodule

// File: rtl/bbs_addr.sv
module bbs_addr #(
    parameter int unsigned AW = 9
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [AW-1:0] load_val,
    input  logic          step,
    output logic [AW-1:0] next_addr
);

    logic [AW-1:0] base_q;
    logic          first_q;

    // address the next access would use
    always_comb begin
        if (load) begin
            next_addr = load_val;
        end else if (first_q) begin
            next_addr = base_q;
        end else begin
            next_addr = base_q + AW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_q  <= '0;
            first_q <= 1'b1;
        end else if (load) begin
            base_q  <= load_val;
            first_q <= !step;
        end else if (step) begin
            base_q  <= next_addr;
            first_q <= 1'b0;
        end
    end

endmodule

// File: rtl/bbs_fsm.sv
module bbs_fsm
    import bbs_pkg::*;
#(
    parameter int unsigned AW         = 9,
    parameter int unsigned DW         = 8,
    parameter int unsigned SETTLE_CYC = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          ds_low_s,
    input  logic          ds_rise,
    input  logic [AW-1:0] acc_addr,
    input  logic [DW-1:0] bus_data,
    output logic          dtack_n,
    output logic          wr_en,
    output logic [AW-1:0] wr_addr,
    output logic [DW-1:0] wr_data,
    output bbs_state_e    state
);

    localparam int unsigned CW = (SETTLE_CYC > 1) ? $clog2(SETTLE_CYC) : 1;
    localparam logic [CW-1:0] CNT_LAST = CW'(SETTLE_CYC - 1);

    bbs_state_e    state_q;
    bbs_state_e    state_d;
    logic [CW-1:0] cnt_q;
    logic [AW-1:0] addr_q;
    logic [DW-1:0] data_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start) begin
                    state_d = ST_SETTLE;
                end
            end
            ST_SETTLE: begin
                if (ds_rise) begin
                    state_d = ST_COMMIT;
                end else if (cnt_q == CNT_LAST) begin
                    state_d = ST_ACK;
                end
            end
            ST_ACK: begin
                if (ds_rise) begin
                    state_d = ST_COMMIT;
                end
            end
            ST_COMMIT: begin
                state_d = ST_IDLE;
            end
        endcase
    end

    // settle counter, access address and data capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            addr_q <= '0;
            data_q <= '0;
        end else begin
            if (state_q == ST_SETTLE) begin
                cnt_q <= cnt_q + CW'(1);
            end else begin
                cnt_q <= '0;
            end
            if (state_q == ST_IDLE && start) begin
                addr_q <= acc_addr;
            end
            if ((state_q == ST_SETTLE || state_q == ST_ACK) && ds_low_s) begin
                data_q <= bus_data;
            end
        end
    end

    // outputs
    always_comb begin
        dtack_n = 1'b1;
        wr_en   = 1'b0;
        unique case (state_q)
            ST_IDLE:   ;
            ST_SETTLE: ;
            ST_ACK:    dtack_n = 1'b0;
            ST_COMMIT: wr_en   = 1'b1;
        endcase
    end

    assign wr_addr = addr_q;
    assign wr_data = data_q;
    assign state   = state_q;

endmodule

// File: rtl/burst_bus_slave.sv
module burst_bus_slave
    import bbs_pkg::*;
#(
    parameter int unsigned AW          = 9,
    parameter int unsigned DW          = 8,
    parameter int unsigned SETTLE_CYC  = 2,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cs_n,
    input  logic          as_n,
    input  logic          rw_n,
    input  logic          ds_n,
    input  logic [AW-1:0] bus_addr,
    input  logic [DW-1:0] bus_data,
    output logic          dtack_n,
    output logic          wr_en,
    output logic [AW-1:0] wr_addr,
    output logic [DW-1:0] wr_data
);

    logic [CTRL_W-1:0] ctrl_raw;
    logic [CTRL_W-1:0] ctrl_s;
    logic [CTRL_W-1:0] ctrl_p;
    logic              cs_s_n;
    logic              rw_s_n;
    logic              ds_fall;
    logic              ds_rise;
    logic              as_fall;
    logic              addr_load;
    logic              acc_start;
    logic [AW-1:0]     acc_addr;
    bbs_state_e        fsm_state;

    always_comb begin
        ctrl_raw         = '1;
        ctrl_raw[IDX_CS] = cs_n;
        ctrl_raw[IDX_AS] = as_n;
        ctrl_raw[IDX_RW] = rw_n;
        ctrl_raw[IDX_DS] = ds_n;
    end

    bbs_sync #(
        .W      (CTRL_W),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .d_raw  (ctrl_raw),
        .q      (ctrl_s),
        .q_prev (ctrl_p)
    );

    assign cs_s_n    = ctrl_s[IDX_CS];
    assign rw_s_n    = ctrl_s[IDX_RW];
    assign ds_fall   = ctrl_p[IDX_DS] & ~ctrl_s[IDX_DS];
    assign ds_rise   = ~ctrl_p[IDX_DS] & ctrl_s[IDX_DS];
    assign as_fall   = ctrl_p[IDX_AS] & ~ctrl_s[IDX_AS];
    assign addr_load = as_fall & ~cs_s_n;
    assign acc_start = (fsm_state == ST_IDLE) & ds_fall & ~cs_s_n & ~rw_s_n;

    bbs_addr #(
        .AW (AW)
    ) u_addr (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (addr_load),
        .load_val  (bus_addr),
        .step      (acc_start),
        .next_addr (acc_addr)
    );

    bbs_fsm #(
        .AW         (AW),
        .DW         (DW),
        .SETTLE_CYC (SETTLE_CYC)
    ) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (acc_start),
        .ds_low_s (~ctrl_s[IDX_DS]),
        .ds_rise  (ds_rise),
        .acc_addr (acc_addr),
        .bus_data (bus_data),
        .dtack_n  (dtack_n),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .state    (fsm_state)
    );

endmodule

// File: rtl/bbs_checker.sv
module bbs_checker
    import bbs_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       dtack_n,
    input logic       wr_en,
    input bbs_state_e state,
    input logic       ds_fall,
    input logic       cs_s_n,
    input logic       rw_s_n
);

    // R1, R6: acknowledge and write pulse are never active together
    a_r6_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && !dtack_n));

    // R6: write pulse lasts one cycle
    a_r6_one_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> !wr_en);

    // R6: acknowledge release coincides with the commit
    a_r6_release_commit: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dtack_n) |-> wr_en);

    // R5: acknowledge only follows the settle phase
    a_r5_ack_after_settle: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dtack_n) |-> ($past(state) == ST_SETTLE));

    // R8: strobe without chip select leaves the machine idle
    a_r8_ignore_unselected: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && ds_fall && cs_s_n) |=> (state == ST_IDLE));

    // R9: read strobe leaves the machine idle
    a_r9_ignore_read: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && ds_fall && rw_s_n) |=> (state == ST_IDLE));

endmodule

bind burst_bus_slave bbs_checker u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .dtack_n (dtack_n),
    .wr_en   (wr_en),
    .state   (fsm_state),
    .ds_fall (ds_fall),
    .cs_s_n  (cs_s_n),
    .rw_s_n  (rw_s_n)
);

// File: tb/burst_bus_slave_tb.sv
`timescale 1ns/1ps
module burst_bus_slave_tb;

    localparam int SETTLE = 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs_n = 1'b1;
    logic       as_n = 1'b1;
    logic       rw_n = 1'b1;
    logic       ds_n = 1'b1;
    logic [8:0] bus_addr = '0;
    logic [7:0] bus_data = '0;
    logic       dtack_n;
    logic       wr_en;
    logic [8:0] wr_addr;
    logic [7:0] wr_data;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    burst_bus_slave #(.SETTLE_CYC(SETTLE)) u_dut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .as_n(as_n), .rw_n(rw_n),
        .ds_n(ds_n), .bus_addr(bus_addr), .bus_data(bus_data),
        .dtack_n(dtack_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    bit h_cs[3], h_as[3], h_rw[3], h_ds[3];
    int m_ph, m_cnt, m_base, m_acc, m_data;
    bit m_first;

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 3; i++) begin
                h_cs[i] = 1; h_as[i] = 1; h_rw[i] = 1; h_ds[i] = 1;
            end
            m_ph = 0; m_cnt = 0; m_base = 0; m_acc = 0; m_data = 0; m_first = 1;
        end else begin
            bit dfall, drise, afall, go;
            int tgt, old_ph;
            dfall = h_ds[2] && !h_ds[1];
            drise = !h_ds[2] && h_ds[1];
            afall = h_as[2] && !h_as[1] && !h_cs[1];
            go    = (m_ph == 0) && dfall && !h_cs[1] && !h_rw[1];
            tgt   = afall ? int'(bus_addr) : (m_first ? m_base : (m_base + 1) % 512);
            old_ph = m_ph;
            case (m_ph)
                0: if (go) begin m_ph = 1; m_cnt = 0; m_acc = tgt; end
                1: begin
                    if (drise) m_ph = 3;
                    else if (m_cnt == SETTLE - 1) m_ph = 2;
                    else m_cnt++;
                end
                2: if (drise) m_ph = 3;
                default: m_ph = 0;
            endcase
            if ((old_ph == 1 || old_ph == 2) && !h_ds[1]) m_data = int'(bus_data);
            if (afall) begin
                m_base = int'(bus_addr); m_first = !go;
            end else if (go) begin
                m_base = tgt; m_first = 0;
            end
            for (int i = 2; i > 0; i--) begin
                h_cs[i] = h_cs[i-1]; h_as[i] = h_as[i-1];
                h_rw[i] = h_rw[i-1]; h_ds[i] = h_ds[i-1];
            end
            h_cs[0] = cs_n; h_as[0] = as_n; h_rw[0] = rw_n; h_ds[0] = ds_n;
        end
    end

    // per-cycle comparison and commit log
    int q_addr[$];
    int q_data[$];
    int ack_low_seen = 0;

    always @(negedge clk) begin
        if (rst_n && !finished) begin
            bit exp_dt, exp_we, ok;
            exp_dt = (m_ph != 2);
            exp_we = (m_ph == 3);
            ok = (dtack_n == exp_dt) && (wr_en == exp_we);
            if (exp_we) ok = ok && (int'(wr_addr) == m_acc) && (int'(wr_data) == m_data);
            chk(ok, "R5/R6 model compare", {dtack_n, wr_en}, {exp_dt, exp_we});
            if (wr_en) begin
                q_addr.push_back(int'(wr_addr));
                q_data.push_back(int'(wr_data));
            end
            if (!dtack_n) ack_low_seen++;
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic load_addr(input int a);
        @(negedge clk);
        bus_addr = 9'(a); as_n = 1'b0;
        repeat (4) @(negedge clk);
        as_n = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    // full handshake; returns negedges to ack and to release
    task automatic write_cycle(input int d, output int t_ack, output int t_rel, output bit pulse_ok);
        int k;
        @(negedge clk);
        bus_data = 8'(d); rw_n = 1'b0; ds_n = 1'b0;
        k = 0;
        do begin @(negedge clk); k++; end while (dtack_n && k < 50);
        t_ack = k;
        ds_n = 1'b1;
        k = 0;
        do begin @(negedge clk); k++; end while (!dtack_n && k < 50);
        t_rel = k;
        pulse_ok = wr_en;
        @(negedge clk);
        pulse_ok = pulse_ok && !wr_en;
        repeat (3) @(negedge clk);
    endtask

    task automatic simple_write(input int d);
        int a, r;
        bit p;
        write_cycle(d, a, r, p);
    endtask

    task automatic pop_chk(input string req, input int ea, input int ed);
        int a, d;
        a = -1; d = -1;
        if (q_addr.size() > 0) begin a = q_addr.pop_front(); d = q_data.pop_front(); end
        chk(a == ea, req, a, ea);
        chk(d == ed, req, d, ed);
    endtask

    // strobe that should be ignored
    task automatic dead_strobe(input bit cs_v, input bit rw_v, input string req);
        int acks0, cnt0;
        acks0 = ack_low_seen; cnt0 = q_addr.size();
        @(negedge clk);
        cs_n = cs_v; rw_n = rw_v; bus_data = 8'hEE; ds_n = 1'b0;
        repeat (10) @(negedge clk);
        ds_n = 1'b1;
        repeat (6) @(negedge clk);
        chk(ack_low_seen == acks0, req, ack_low_seen - acks0, 0);
        chk(q_addr.size() == cnt0, req, q_addr.size() - cnt0, 0);
        cs_n = 1'b0; rw_n = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    // watchdog
    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog actual=timeout expected=done");
            finished = 1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        int ta, tr, acks0;
        bit po;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(dtack_n == 1'b1, "R1 dtack_n in reset", dtack_n, 1);
        chk(wr_en == 1'b0, "R1 wr_en in reset", wr_en, 0);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        chk(q_addr.size() == 0, "R1 no pulse after reset", q_addr.size(), 0);
        cs_n = 1'b0;
        repeat (3) @(negedge clk);

        // R2, R3, R5, R6, R7: burst from 0x010
        load_addr(9'h010);
        write_cycle(8'hA1, ta, tr, po);
        chk(ta == SETTLE + 3, "R5 acknowledge delay", ta, SETTLE + 3);
        chk(tr == 3, "R6 release delay", tr, 3);
        chk(po, "R6 single write pulse at release", po, 1);
        pop_chk("R2 R7 first write at offset 0", 9'h010, 8'hA1);
        simple_write(8'hB2);
        pop_chk("R3 second write increments", 9'h011, 8'hB2);
        simple_write(8'hC3);
        pop_chk("R3 third write increments", 9'h012, 8'hC3);

        // R4 wrap
        load_addr(9'h1FE);
        simple_write(8'h11);
        pop_chk("R4 write at 0x1FE", 9'h1FE, 8'h11);
        simple_write(8'h22);
        pop_chk("R4 write at 0x1FF", 9'h1FF, 8'h22);
        simple_write(8'h33);
        pop_chk("R4 wrap to 0x000", 9'h000, 8'h33);

        // R8 unselected strobe, then address must not have advanced
        dead_strobe(1'b1, 1'b0, "R8 unselected strobe ignored");
        simple_write(8'h44);
        pop_chk("R8 address not advanced", 9'h001, 8'h44);

        // R9 read strobe ignored
        dead_strobe(1'b0, 1'b1, "R9 read strobe ignored");
        simple_write(8'h55);
        pop_chk("R9 address not advanced", 9'h002, 8'h55);

        // R10 restart mid burst
        load_addr(9'h055);
        simple_write(8'h66);
        pop_chk("R10 restart at new address", 9'h055, 8'h66);
        simple_write(8'h77);
        pop_chk("R10 count from new address", 9'h056, 8'h77);

        // R11 short strobe
        acks0 = ack_low_seen;
        @(negedge clk);
        bus_data = 8'h9C; rw_n = 1'b0; ds_n = 1'b0;
        repeat (2) @(negedge clk);
        ds_n = 1'b1;
        repeat (8) @(negedge clk);
        chk(ack_low_seen == acks0, "R11 no acknowledge on short strobe", ack_low_seen - acks0, 0);
        chk(q_addr.size() == 1, "R11 exactly one commit", q_addr.size(), 1);
        pop_chk("R11 short strobe commit", 9'h057, 8'h9C);

        repeat (5) @(negedge clk);
        finished = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule